// File: doc/BRIEF.md
# Conditional Sum Adder

A purely combinational binary adder of parameterised width. It takes two unsigned operands and a carry-in, and returns their sum and the carry leaving the most significant bit. The carry is not passed from bit to bit. Every bit position first produces two provisional results: one assumes an incoming carry of 0 and the other assumes an incoming carry of 1. A tree of multiplexer levels then joins neighbouring sections, and the section width doubles at each level. At each join, the lower half's provisional carry-out chooses which of the upper half's two candidate results is kept.

After log2 of the width levels, one section spans the whole word and still holds two complete candidates. The real carry-in chooses between them. The worst-case path is therefore one cell followed by a chain of 2:1 multiplexers whose length grows with the logarithm of the width.

If the width is not a power of two, the operands are widened internally with zeros to the next power of two. The extra sum bits are dropped, and the carry is taken from the sum bit just above the real width.

Top module: `cond_sum_adder`

## Requirements
- R1: For every input, {cout, sum} equals the arithmetic value op_a + op_b + cin, taken over WIDTH+1 bits.
- R2: With op_b = 0 and cin = 0, sum equals op_a and cout is 0.
- R3: With op_a all ones, op_b = 0 and cin = 1, sum is all zeros and cout is 1. In this case a carry crosses every section boundary.
- R4: With op_b = ~op_a, cin = 0 gives sum all ones and cout = 0, and cin = 1 gives sum all zeros and cout = 1.
- R5: cout is 1 exactly when op_a + op_b + cin is at least 2^WIDTH.
- R6: When WIDTH is not a power of two (for example 12), R1 and R5 still hold, with cout being the carry out of bit WIDTH-1.
- R7: The block holds no state. The outputs follow the inputs within the same time step, without any clock edge.
- R8: For fixed operands, switching cin from 0 to 1 raises {cout, sum} by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Two things can happen in one evaluation: the chain of section-level selections carries a 1 across every merge boundary, and the final carry-in select switches between the two complete candidates. The bench provokes both together with all-ones, complement and alternating operands while cin toggles between consecutive vectors. It judges each result against an integer sum computed independently, at widths 8, 12, 16 and 32.

// File: rtl/csa_pkg.sv
// Package: shared helpers for the conditional sum adder.
// Assumes: widths are positive.
package csa_pkg;

    // Rounds a width up to the next power of two.
    function automatic int unsigned csa_pad_width(input int unsigned w);
        return 1 << $clog2(w);
    endfunction

    // Chooses between the two candidates of a pair under one select line.
    function automatic logic csa_pick(input logic sel, input logic when0, input logic when1);
        return sel ? when1 : when0;
    endfunction

endpackage

// File: rtl/csa_cond_cell_row.sv
// Module: a row of conditional cells, one for each padded bit position.
// Each cell gives a sum/carry pair for an assumed carry-in of 0 and a second
// pair for an assumed carry-in of 1. Neither pair depends on the real carry.
// Assumes: PW is a power of two.
module csa_cond_cell_row #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic [PW-1:0] s_if0,
    output logic [PW-1:0] s_if1,
    output logic [PW-1:0] c_if0,
    output logic [PW-1:0] c_if1
);
    for (genvar i = 0; i < PW; i++) begin : g_cell
        logic half;
        // Purpose: the half-sum that both candidate pairs share.
        assign half     = x[i] ^ y[i];
        // Purpose: the candidate pair for an assumed carry-in of 0.
        assign s_if0[i] = half;
        assign c_if0[i] = x[i] & y[i];
        // Purpose: the candidate pair for an assumed carry-in of 1.
        assign s_if1[i] = ~half;
        assign c_if1[i] = x[i] | y[i];
    end
endmodule

// File: rtl/csa_merge_level.sv
// Module: one merge level. It joins neighbouring sections of K bits into
// sections of 2K bits. The lower section's bits pass through unchanged. For
// each assumption, the lower section's provisional carry selects the upper
// section's candidate pair, and all of its sum bits and its carry switch
// together.
// Assumes: PW is a power of two and K divides PW/2.
module csa_merge_level #(
    parameter int PW = 16,
    parameter int K  = 1
) (
    input  logic [PW-1:0]          in_s0,
    input  logic [PW-1:0]          in_s1,
    input  logic [PW/K-1:0]        in_c0,
    input  logic [PW/K-1:0]        in_c1,
    output logic [PW-1:0]          out_s0,
    output logic [PW-1:0]          out_s1,
    output logic [PW/(2*K)-1:0]    out_c0,
    output logic [PW/(2*K)-1:0]    out_c1
);
    localparam int NOUT = PW / (2 * K);

    for (genvar p = 0; p < NOUT; p++) begin : g_pair
        localparam int LB = 2 * p * K;
        localparam int UB = LB + K;
        logic sel0, sel1;

        // Purpose: the lower section's carries, one for each assumption.
        assign sel0 = in_c0[2*p];
        assign sel1 = in_c1[2*p];

        // Purpose: the lower half passes through unchanged.
        assign out_s0[LB +: K] = in_s0[LB +: K];
        assign out_s1[LB +: K] = in_s1[LB +: K];

        // Purpose: the upper half takes the candidate chosen by the lower carry.
        for (genvar q = 0; q < K; q++) begin : g_bit
            assign out_s0[UB+q] = csa_pkg::csa_pick(sel0, in_s0[UB+q], in_s1[UB+q]);
            assign out_s1[UB+q] = csa_pkg::csa_pick(sel1, in_s0[UB+q], in_s1[UB+q]);
        end

        // Purpose: the merged section's carry is the selected upper carry.
        assign out_c0[p] = csa_pkg::csa_pick(sel0, in_c0[2*p+1], in_c1[2*p+1]);
        assign out_c1[p] = csa_pkg::csa_pick(sel1, in_c0[2*p+1], in_c1[2*p+1]);
    end
endmodule

// File: rtl/csa_final_pick.sv
// Module: the last step. The real carry-in chooses between the two
// candidates that each span the whole word.
// Assumes: both candidates are complete.
module csa_final_pick #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] s_if0,
    input  logic [PW-1:0] s_if1,
    input  logic          c_if0,
    input  logic          c_if1,
    input  logic          carry_in,
    output logic [PW-1:0] full_sum,
    output logic          full_carry
);
    // Purpose: select the whole sum word and its carry under one line.
    always_comb begin
        full_sum   = carry_in ? s_if1 : s_if0;
        full_carry = csa_pkg::csa_pick(carry_in, c_if0, c_if1);
    end
endmodule

// File: rtl/cond_sum_adder.sv
// Module: top of the conditional sum adder. It is combinational and has no
// clock or reset. It pads the operands to a power of two, builds the cell row
// and log2 merge levels, and makes the final carry-in selection.
// Assumes: WIDTH >= 1. When WIDTH is not a power of two, cout is read from the
// padded sum bit just above the real width.
module cond_sum_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int PW     = csa_pkg::csa_pad_width(WIDTH);
    localparam int LEVELS = $clog2(PW);

    logic [PW-1:0] a_pad, b_pad;
    logic [PW-1:0] full_sum;
    logic          full_carry;

    // Purpose: widen the operands with zeros to the padded width.
    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[WIDTH-1:0] = op_a;
        b_pad[WIDTH-1:0] = op_b;
    end

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int NSEC = PW >> l;
        logic [PW-1:0]   s0, s1;
        logic [NSEC-1:0] c0, c1;
        if (l == 0) begin : g_cells
            csa_cond_cell_row #(.PW(PW)) u_cells (
                .x     (a_pad),
                .y     (b_pad),
                .s_if0 (s0),
                .s_if1 (s1),
                .c_if0 (c0),
                .c_if1 (c1)
            );
        end else begin : g_merge
            csa_merge_level #(.PW(PW), .K(1 << (l - 1))) u_merge (
                .in_s0  (g_lvl[l-1].s0),
                .in_s1  (g_lvl[l-1].s1),
                .in_c0  (g_lvl[l-1].c0),
                .in_c1  (g_lvl[l-1].c1),
                .out_s0 (s0),
                .out_s1 (s1),
                .out_c0 (c0),
                .out_c1 (c1)
            );
        end
    end

    csa_final_pick #(.PW(PW)) u_final (
        .s_if0      (g_lvl[LEVELS].s0),
        .s_if1      (g_lvl[LEVELS].s1),
        .c_if0      (g_lvl[LEVELS].c0[0]),
        .c_if1      (g_lvl[LEVELS].c1[0]),
        .carry_in   (cin),
        .full_sum   (full_sum),
        .full_carry (full_carry)
    );

    // Purpose: drop the padding and take the carry from the real top bit.
    if (PW == WIDTH) begin : g_exact
        assign sum  = full_sum;
        assign cout = full_carry;
    end else begin : g_padded
        assign sum  = full_sum[WIDTH-1:0];
        assign cout = full_sum[WIDTH];
    end
endmodule

// File: rtl/cond_sum_adder_checker.sv
// Module: checks the adder's ports against plain arithmetic. It is attached
// to every instance of the top through bind.
// Assumes: combinational inputs have settled when the checks are evaluated.
module cond_sum_adder_checker #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic [WIDTH:0] arith;

    // Purpose: compare the outputs with an arithmetic sum and with the special cases.
    always_comb begin
        arith = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};
        if (!$isunknown({op_a, op_b, cin})) begin
            a_r1_total_matches: assert ({cout, sum} == arith)
                else $error("R1 total mismatch");
            a_r5_carry_flag: assert (cout == (arith >= (WIDTH+1)'(1) << WIDTH))
                else $error("R5 carry flag mismatch");
            if (op_b == '0 && !cin)
                a_r2_zero_identity: assert (sum == op_a && !cout)
                    else $error("R2 identity mismatch");
            if (op_b == ~op_a)
                a_r4_complement: assert (cout == cin && sum == {WIDTH{~cin}})
                    else $error("R4 complement mismatch");
            if (op_a == '1 && op_b == '0 && cin)
                a_r3_full_chain: assert (sum == '0 && cout)
                    else $error("R3 chain mismatch");
        end
    end
endmodule

bind cond_sum_adder cond_sum_adder_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a (op_a),
    .op_b (op_b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/cond_sum_adder_test.sv
module cond_sum_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] a_in = '0, b_in = '0;
    logic        c_in = 1'b0;

    logic [15:0] s16; logic co16;
    logic [7:0]  s8;  logic co8;
    logic [31:0] s32; logic co32;
    logic [11:0] s12; logic co12;

    cond_sum_adder #(.WIDTH(16)) uut (
        .op_a(a_in[15:0]), .op_b(b_in[15:0]), .cin(c_in), .sum(s16), .cout(co16));
    cond_sum_adder #(.WIDTH(8)) uut_w8 (
        .op_a(a_in[7:0]), .op_b(b_in[7:0]), .cin(c_in), .sum(s8), .cout(co8));
    cond_sum_adder #(.WIDTH(32)) uut_w32 (
        .op_a(a_in), .op_b(b_in), .cin(c_in), .sum(s32), .cout(co32));
    cond_sum_adder #(.WIDTH(12)) uut_w12 (
        .op_a(a_in[11:0]), .op_b(b_in[11:0]), .cin(c_in), .sum(s12), .cout(co12));

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    longint unsigned exp_q[$];

    // Compares one value against its expectation and reports a mismatch.
    task automatic judge(input string req, input longint unsigned got, input longint unsigned exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Expected value for width w: an integer sum, masked to w+1 bits.
    function automatic longint unsigned model(input int w, input logic [31:0] a,
                                              input logic [31:0] b, input logic c);
        longint unsigned m = (64'd1 << w) - 1;
        return ((longint'(a) & m) + (longint'(b) & m) + longint'(c)) & ((m << 1) | 1);
    endfunction

    // Drives one vector at a rising edge and checks all widths at the falling edge.
    task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic c,
                           input string req);
        @(posedge clk);
        a_in = a; b_in = b; c_in = c;
        exp_q.push_back(model(16, a, b, c));
        exp_q.push_back(model(8, a, b, c));
        exp_q.push_back(model(32, a, b, c));
        exp_q.push_back(model(12, a, b, c));
        @(negedge clk);
        judge({req, " w16"}, {co16, s16}, exp_q.pop_front());
        judge({req, " w8"},  {co8, s8},   exp_q.pop_front());
        judge({req, " w32"}, {co32, s32}, exp_q.pop_front());
        judge({req, " R6 w12"}, {co12, s12}, exp_q.pop_front());
        judge("R5 carry w16", co16, model(16, a, b, c) >> 16);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired got=%0d exp<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [16:0] lo, hi;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: all-zero inputs give a zero result.
        judge("R2 reset w16", {co16, s16}, 0);

        run_vec(32'h0000_0000, 32'h0000_0000, 1'b0, "R2 zeros");
        run_vec(32'h1234_5678, 32'h0000_0000, 1'b0, "R2 pass");
        run_vec(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R3 chain");
        run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1 ones");
        run_vec(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R4 alt cin0");
        run_vec(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 alt cin1");
        run_vec(32'h5555_5555, 32'h5555_5555, 1'b1, "R1 alt same");
        run_vec(32'h8000_8080, 32'h8000_8080, 1'b0, "R5 top bits");

        // R8: cin toggle on fixed operands raises the result by one.
        run_vec(32'h0F0F_00FF, 32'h00F0_0F01, 1'b0, "R8 base");
        lo = {co16, s16};
        run_vec(32'h0F0F_00FF, 32'h00F0_0F01, 1'b1, "R8 inc");
        hi = {co16, s16};
        judge("R8 step", hi, lo + 17'd1);

        // R7: outputs follow inputs with no clock edge in between.
        @(negedge clk);
        a_in = 32'h0000_7FFF; b_in = 32'h0000_0001; c_in = 1'b0;
        #1;
        judge("R7 no clock w16", {co16, s16}, 17'h0_8000);
        c_in = 1'b1;
        #1;
        judge("R7 no clock w16 cin", {co16, s16}, 17'h0_8001);

        for (int i = 0; i < 10000; i++) begin
            run_vec($urandom, $urandom, 1'($urandom), "R1 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule